// File: doc/BRIEF.md
# Oscillator Frequency Calibration Search

This block tunes an on-chip digitally controlled oscillator against a slow, accurate reference clock. When `start` is pulsed it runs a successive-approximation search over a 12-bit control word. Bit 11 is tried first and bit 0 last. Each trial drives the candidate word onto the oscillator's control pins and measures how many oscillator cycles fit into a fixed number of reference periods. The trial bit is kept when that count does not exceed the requested target.

The oscillator's cycle count arrives on `osc_count` as a free-running 16-bit counter that is already in the block's clock domain. The reference clock arrives asynchronously on `ref_clk_in`, and the block synchronises it and detects its rising edges.

Each trial spans two back-to-back measurement windows. The first window absorbs the oscillator's settling after the word change. Only the count taken over the second window is compared with the target. When the search ends, a saturated coarse-tap field causes the modulation field to be cleared. The resulting word is then applied and `done` is pulsed.

The target is the wanted oscillator frequency divided by the reference frequency, multiplied by the window length.

Top module: `dco_cal_sar`

## Requirements
- R1: While `rst` is high and after it falls, `range_sel`, `fine_ctl` and `done` are all zero until a calibration changes them.
- R2: The applied word is split with bits 10:8 on `range_sel` and bits 7:0 on `fine_ctl`. Within `fine_ctl`, bits 7:5 are the coarse tap and bits 4:0 the modulation. Bit 11 takes part in the search but drives no pin.
- R3: A start clears the word and first applies trial bit 11 (word 0x800). After each decided trial the next lower bit is set on top of the word built so far and applied, down to bit 0.
- R4: A trial bit is kept exactly when the measured count, read as unsigned, is less than or equal to `target` (equality keeps it).
- R5: A window closes on every 8th synchronised reference rising edge after a trial begins. Each trial waits for two window closures, and its count is the `osc_count` value at the second closure minus the value at the first.
- R6: The count difference is taken modulo 2^16, so a wrap of `osc_count` between captures still yields the true cycle count.
- R7: After the last trial, if word bits 7:5 are all one, bits 4:0 are forced to zero before the word is applied.
- R8: `done` is high for exactly one cycle, in the cycle where the final word first appears on the outputs, and the outputs then hold that word.
- R9: A `start` pulse while a calibration is running is ignored and changes neither the result nor the completion time.
- R10: `ref_clk_in` passes through a two-stage synchroniser. A rising edge counts as a reference tick at the second clock edge after the first edge that samples it high.
- R11: The search makes no assumption that the count rises with the word. Each bit is decided only by its own measurement, even when the range field maps to frequencies out of order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the domain of `osc_count` |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse to begin a calibration (ignored while one runs) |
| ref_clk_in | input | 1 | Asynchronous slow reference clock |
| target | input | 12 | Allowed oscillator cycles per measurement window |
| osc_count | input | 16 | Free-running oscillator cycle counter, wraps |
| range_sel | output | 3 | Range select, word bits 10:8 |
| fine_ctl | output | 8 | Coarse tap (7:5) and modulation (4:0), word bits 7:0 |
| done | output | 1 | One-cycle pulse when the final word is applied |

## Verification
A reference rising edge is seen as a tick two clock edges after it is first sampled. The window closes and the capture registers at the edge that consumes the 8th tick. The controller acts on that capture one edge later, so a new trial word, or the final word together with `done`, appears one cycle after the second capture.

The bench keeps its own cycle-by-cycle model of these latencies, fed only by the block's inputs, and compares every output at each falling clock edge. Inputs change on falling edges, so no comparison depends on ordering within an edge.

Closed-form checks of the final word, of the one-cycle `done`, and of an unchanged completion time when a stray start arrives are taken once the `done` pulse is seen.

// File: rtl/dcs_pkg.sv
package dcs_pkg;
  // Search controller state: waiting for start, or stepping through trials.
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } sar_state_e;
endpackage

// File: rtl/dcs_ref_sync.sv
module dcs_ref_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_async,
  output logic tick
);
  // sh[STAGES-1] is the synchronised level, sh[STAGES] its previous value.
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[STAGES-1:0], ref_async};
  end

  assign tick = sh[STAGES-1] & ~sh[STAGES];

  // R10: an edge pulse lasts one cycle only
  a_r10_tick_isolated: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
endmodule

// File: rtl/dcs_window_meter.sv
module dcs_window_meter #(
  parameter int CNT_W = 16,
  parameter int WIN   = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             tick,
  input  logic [CNT_W-1:0] osc_count,
  output logic             win_done,
  output logic [CNT_W-1:0] delta
);
  localparam int WCW = (WIN > 1) ? $clog2(WIN) : 1;
  localparam logic [WCW-1:0] LAST = WCW'(WIN - 1);

  logic [WCW-1:0]   tcnt;
  logic [CNT_W-1:0] cap_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tcnt     <= '0;
      cap_q    <= '0;
      delta    <= '0;
      win_done <= 1'b0;
    end else begin
      win_done <= 1'b0;
      if (restart) begin
        tcnt <= '0;
      end else if (tick) begin
        if (tcnt == LAST) begin
          tcnt     <= '0;
          cap_q    <= osc_count;
          delta    <= osc_count - cap_q;   // modulo 2^CNT_W
          win_done <= 1'b1;
        end else begin
          tcnt <= tcnt + 1'b1;
        end
      end
    end
  end

  // R5: a window can only close on a reference tick outside a restart
  a_r5_close_on_tick: assert property (@(posedge clk) disable iff (rst)
    win_done |-> ($past(tick) && !$past(restart)));
  // R6: the capture that closes a window is the counter value of that edge
  a_r6_capture_value: assert property (@(posedge clk) disable iff (rst)
    win_done |-> (cap_q == $past(osc_count)));
endmodule

// File: rtl/dcs_sar_ctrl.sv
module dcs_sar_ctrl
  import dcs_pkg::*;
#(
  parameter int CW         = 12,
  parameter int CNT_W      = 16,
  parameter int TGT_W      = 12,
  parameter int APPLY_W    = 11,
  parameter int COARSE_LSB = 5,
  parameter int COARSE_W   = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [TGT_W-1:0]   target,
  input  logic               win_done,
  input  logic [CNT_W-1:0]   delta,
  output logic               restart,
  output logic [APPLY_W-1:0] apply_word,
  output logic               done
);
  localparam int COARSE_MSB = COARSE_LSB + COARSE_W - 1;
  localparam logic [CW-1:0] TOP_BIT = CW'(1) << (CW - 1);

  sar_state_e        state;
  logic              phase;      // 0: settling window, 1: measuring window
  logic [CW-1:0]     trial;
  logic [CW-1:0]     word;
  logic [CW-1:0]     kept_word;
  logic [CW-1:0]     final_word;
  logic [APPLY_W-1:0] next_apply;
  logic              kept;

  assign kept       = (delta <= CNT_W'(target));
  assign kept_word  = kept ? (word | trial) : word;
  assign next_apply = kept_word[APPLY_W-1:0] | trial[APPLY_W:1];

  // Saturated coarse tap leaves no room for modulation: clear it.
  always_comb begin
    final_word = kept_word;
    if (&kept_word[COARSE_MSB:COARSE_LSB])
      final_word[COARSE_LSB-1:0] = '0;
  end

  assign restart = (state == ST_IDLE) ? start : (win_done & phase);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      phase      <= 1'b0;
      trial      <= '0;
      word       <= '0;
      apply_word <= '0;
      done       <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            state      <= ST_RUN;
            phase      <= 1'b0;
            word       <= '0;
            trial      <= TOP_BIT;
            apply_word <= TOP_BIT[APPLY_W-1:0];
          end
        end
        ST_RUN: begin
          if (win_done) begin
            if (!phase) begin
              phase <= 1'b1;
            end else begin
              phase <= 1'b0;
              if (trial[0]) begin
                state      <= ST_IDLE;
                trial      <= '0;
                word       <= final_word;
                apply_word <= final_word[APPLY_W-1:0];
                done       <= 1'b1;
              end else begin
                word       <= kept_word;
                trial      <= trial >> 1;
                apply_word <= next_apply;
              end
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R8: completion is a single-cycle pulse
  a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R9: a start during a run does not leave the running state
  a_r9_start_ignored: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUN && start && !(win_done && phase && trial[0])) |=> (state == ST_RUN));
  // R3: the trial bit walks one position down per decided trial
  a_r3_trial_walk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUN && win_done && phase && !trial[0]) |=> (trial == ($past(trial) >> 1)));
  // R4: the decided bit is set exactly when the count is within target
  a_r4_keep_rule: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUN && win_done && phase && !trial[0]) |=>
      (((word & $past(trial)) != '0) == ($past(delta) <= CNT_W'($past(target)))));
  // R7: a finished word never carries modulation under a saturated coarse tap
  a_r7_fixup: assert property (@(posedge clk) disable iff (rst)
    done |-> !((&apply_word[COARSE_MSB:COARSE_LSB]) && (|apply_word[COARSE_LSB-1:0])));
endmodule

// File: rtl/dco_cal_sar.sv
module dco_cal_sar #(
  parameter int CTL_W       = 12,
  parameter int CNT_W       = 16,
  parameter int TGT_W       = 12,
  parameter int WIN_REFS    = 8,
  parameter int SYNC_STAGES = 2,
  parameter int FINE_W      = 8,
  parameter int RANGE_W     = 3,
  parameter int COARSE_W    = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic               ref_clk_in,
  input  logic [TGT_W-1:0]   target,
  input  logic [CNT_W-1:0]   osc_count,
  output logic [RANGE_W-1:0] range_sel,
  output logic [FINE_W-1:0]  fine_ctl,
  output logic               done
);
  localparam int APPLY_W    = FINE_W + RANGE_W;
  localparam int COARSE_LSB = FINE_W - COARSE_W;

  logic             tick;
  logic             restart;
  logic             win_done;
  logic [CNT_W-1:0] delta;
  logic [APPLY_W-1:0] apply_word;

  dcs_ref_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .ref_async (ref_clk_in),
    .tick      (tick)
  );

  dcs_window_meter #(.CNT_W(CNT_W), .WIN(WIN_REFS)) u_meter (
    .clk       (clk),
    .rst       (rst),
    .restart   (restart),
    .tick      (tick),
    .osc_count (osc_count),
    .win_done  (win_done),
    .delta     (delta)
  );

  dcs_sar_ctrl #(
    .CW         (CTL_W),
    .CNT_W      (CNT_W),
    .TGT_W      (TGT_W),
    .APPLY_W    (APPLY_W),
    .COARSE_LSB (COARSE_LSB),
    .COARSE_W   (COARSE_W)
  ) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .target     (target),
    .win_done   (win_done),
    .delta      (delta),
    .restart    (restart),
    .apply_word (apply_word),
    .done       (done)
  );

  assign fine_ctl  = apply_word[FINE_W-1:0];
  assign range_sel = apply_word[APPLY_W-1:FINE_W];
endmodule

// File: tb/dco_cal_sar_bench.sv
module dco_cal_sar_bench;
  localparam int CLK_PERIOD = 10;
  localparam int RUN_LIMIT  = 20000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        ref_in = 1'b0;
  logic [11:0] target = '0;
  logic [31:0] acc = 32'h000F_FF00;   // oscillator counter starts near wrap (R6)
  logic [15:0] osc;
  logic [2:0]  range_sel;
  logic [7:0]  fine_ctl;
  logic        done;
  int          ref_half = 8;
  bit          scramble = 1'b0;
  bit          cmp_on = 1'b0;
  int          rcnt = 0;
  int          n_chk = 0;
  int          n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dco_cal_sar u_dco_cal_sar (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .ref_clk_in (ref_in),
    .target     (target),
    .osc_count  (osc),
    .range_sel  (range_sel),
    .fine_ctl   (fine_ctl),
    .done       (done)
  );

  // Reference clock: period 2*ref_half clock cycles, driven off the active edge.
  always @(negedge clk) begin
    rcnt   <= (rcnt + 1 >= 2 * ref_half) ? 0 : rcnt + 1;
    ref_in <= (rcnt + 1 >= 2 * ref_half) ? 1'b1 : (rcnt + 1 < ref_half);
  end

  // Oscillator plant: 1/16 cycle per unit of rate each clock.
  always @(posedge clk) begin
    if (scramble) acc <= acc + 32'({range_sel ^ 3'b101, fine_ctl}) + 32'd1;
    else          acc <= acc + 32'({range_sel, fine_ctl}) + 32'd1;
  end
  assign osc = acc[19:4];

  // Behavioural reference model, fed only by the block's inputs.
  logic [2:0]  rq;
  int          m_cnt, m_bit;
  logic [15:0] m_cap, m_delta;
  logic        m_strobe, m_run, m_phase, m_done;
  logic [11:0] m_word, m_ctl;

  always @(posedge clk) begin
    logic tk, rs, os;
    logic [15:0] od;
    logic [11:0] nw;
    if (rst) begin
      rq = '0; m_cnt = 0; m_cap = '0; m_delta = '0; m_strobe = 1'b0;
      m_run = 1'b0; m_phase = 1'b0; m_bit = 0; m_word = '0; m_ctl = '0; m_done = 1'b0;
    end else begin
      tk = rq[1] & ~rq[2];
      rq = {rq[1:0], ref_in};
      os = m_strobe;
      od = m_delta;
      rs = m_run ? (os & m_phase) : start;
      m_done = 1'b0;
      if (!m_run) begin
        if (start) begin
          m_run = 1'b1; m_word = '0; m_bit = 11; m_phase = 1'b0; m_ctl = 12'h800;
        end
      end else if (os) begin
        if (!m_phase) m_phase = 1'b1;
        else begin
          m_phase = 1'b0;
          nw = (od <= {4'b0, target}) ? (m_word | (12'd1 << m_bit)) : m_word;
          if (m_bit == 0) begin
            if (nw[7:5] == 3'b111) nw[4:0] = '0;
            m_word = nw; m_ctl = nw; m_done = 1'b1; m_run = 1'b0;
          end else begin
            m_word = nw; m_bit = m_bit - 1; m_ctl = nw | (12'd1 << m_bit);
          end
        end
      end
      m_strobe = 1'b0;
      if (rs) m_cnt = 0;
      else if (tk) begin
        if (m_cnt == 7) begin
          m_cnt = 0; m_delta = osc - m_cap; m_cap = osc; m_strobe = 1'b1;
        end else m_cnt = m_cnt + 1;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Per-cycle comparison against the model.
  always @(negedge clk) begin
    if (cmp_on) begin
      chk("R2 R3 R4 R5 R6 R10 R11 range_sel per cycle", 32'(range_sel), 32'(m_ctl[10:8]));
      chk("R2 R3 R4 R5 R6 R10 R11 fine_ctl per cycle", 32'(fine_ctl), 32'(m_ctl[7:0]));
      chk("R8 done per cycle", 32'(done), 32'(m_done));
    end
  end

  function automatic logic [11:0] expect_word(input int t);
    logic [11:0] w;
    if (t < 8) return 12'h000;
    w = 12'h800 | 12'(t / 8 - 1);
    if (w[7:5] == 3'b111) w[4:0] = '0;
    return w;
  endfunction

  task automatic run_cal(input int t, input bit stray, output int cycles);
    int n;
    target = 12'(t);
    do @(negedge clk); while (rcnt != 3);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 1;
    while (!done && n < RUN_LIMIT) begin
      @(negedge clk);
      n++;
      if (stray && n == 1000) start = 1'b1;
      else start = 1'b0;
    end
    start = 1'b0;
    if (n >= RUN_LIMIT) begin
      n_chk++; n_fail++;
      $display("FAIL R8 run watchdog: actual no done expected done within %0d", RUN_LIMIT);
    end
    cycles = n;
  endtask

  task automatic check_final(input string req, input int t);
    logic [11:0] w;
    logic [2:0]  r0;
    logic [7:0]  f0;
    w = expect_word(t);
    chk(req, 32'({range_sel, fine_ctl}), 32'(w[10:0]));
    r0 = range_sel; f0 = fine_ctl;
    @(negedge clk);
    chk("R8 done falls after one cycle", 32'(done), 32'd0);
    chk("R8 final word held", 32'({range_sel, fine_ctl}), 32'({r0, f0}));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL global watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int d0, d1, dx;
    repeat (4) @(negedge clk);
    chk("R1 range_sel in reset", 32'(range_sel), 32'd0);
    chk("R1 fine_ctl in reset", 32'(fine_ctl), 32'd0);
    chk("R1 done in reset", 32'(done), 32'd0);
    rst = 1'b0;
    cmp_on = 1'b1;
    repeat (40) @(negedge clk);
    chk("R1 outputs idle after reset", 32'({range_sel, fine_ctl, done}), 32'd0);

    run_cal(1000, 1'b0, d0);          // counter wraps during this run
    check_final("R4 R6 result 1000", 1000);
    run_cal(2040, 1'b0, dx);
    check_final("R7 saturated coarse tap 2040", 2040);
    run_cal(4095, 1'b0, dx);
    check_final("R2 R7 range bit set 4095", 4095);
    run_cal(16, 1'b0, dx);
    check_final("R4 equality keeps bit 16", 16);
    run_cal(5, 1'b0, dx);
    check_final("R4 below every count 5", 5);
    run_cal(1000, 1'b1, d1);
    check_final("R9 result with stray start", 1000);
    chk("R9 completion time with stray start", 32'(d1), 32'(d0));

    scramble = 1'b1;                  // out-of-order range mapping
    run_cal(2000, 1'b0, dx);
    chk("R11 finishes with out-of-order range", 32'(dx < RUN_LIMIT), 32'd1);
    @(negedge clk);
    scramble = 1'b0;

    ref_half = 13;                    // different reference period
    run_cal(3000, 1'b0, dx);
    chk("R5 R10 finishes with 26-cycle reference", 32'(dx < RUN_LIMIT), 32'd1);
    repeat (5) @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule